// File: doc/BRIEF.md
# Slow Idle Clock Controller

This block sits beside the program sequencer and decides, cycle by cycle, whether the core may issue instructions and at what rate the core and its peripheral clocks advance. An idle request comes with an optional divisor. Without a divisor, the core stops issuing instructions. The serial clock, clock output and timer enables keep running, so that an interrupt source can still fire. With a divisor, the processor stays fully functional. The core enable and every derived enable then pulse once every 16, 32, 64 or 128 cycles.

Either form of idle ends only when a pending interrupt is also enabled. On that event the block returns to the full rate on the next cycle. It raises a one-cycle wake strobe, so that the sequencer services the interrupt and then continues after the idle instruction. Real clock gating is not done here. Consumers qualify their registers with the enables.

Top module: `slow_idle_ctl`

## Requirements
- R1: During and right after reset the block is running: halt=0, slow_active=0, wake=0, and core_ce, sclk_ce, clkout_ce and timer_ce are all 1.
- R2: An idle request with div_valid=0 (div_code is then ignored) sets halt=1 and core_ce=0 from the next cycle. sclk_ce, clkout_ce and timer_ce stay 1 while halted.
- R3: While halted, an interrupt whose irq_en bit is 0 does not end the halt.
- R4: While halted, any bit set in both irq_pend and irq_en gives halt=0 and core_ce=1 on the next cycle, with wake=1 in that cycle.
- R5: An idle request with div_valid=1 enters slow mode. div_code 00 selects N=16, 01 selects N=32, 10 selects N=64 and 11 selects N=128. core_ce is high in exactly one cycle of every N. Its first pulse falls in the N-th cycle of slow mode, because the divide counter starts at zero on entry.
- R6: halt stays 0 throughout slow mode, and slow_active stays 1.
- R7: In slow mode, sclk_ce, clkout_ce and timer_ce pulse in exactly the same cycles as core_ce.
- R8: An enabled pending interrupt in slow mode gives slow_active=0 and core_ce=1 on the next cycle, with wake=1 in that cycle.
- R9: While in slow mode, idle requests and changes to div_code have no effect on the enable period.
- R10: If an idle request meets an enabled pending interrupt in the same cycle, the request is dropped. The block stays running and pulses wake on the next cycle.
- R11: wake is high for a single cycle per exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Idle instruction issued this cycle |
| div_valid | input | 1 | A divisor accompanies the request (slow idle) |
| div_code | input | 2 | Divisor select: 00=16, 01=32, 10=64, 11=128 |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line enable, 1 = unmasked |
| halt | output | 1 | Instruction issue stalled (standard idle) |
| slow_active | output | 1 | Slow idle in effect |
| wake | output | 1 | One-cycle strobe after an idle exit |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial clock enable |
| clkout_ce | output | 1 | Clock output enable |
| timer_ce | output | 1 | Timer tick enable |

## Verification
Two events can arrive in one cycle: the idle request that would enter a low-power state, and the enabled interrupt that ends one. The bench raises both together, once with a divisor and once without. It expects the block to stay at full rate with a wake strobe on the following cycle, never to enter halt or slow mode. The same wake logic is also triggered from inside each state after a long dwell. Comparing the two cases shows that the collision follows the same exit timing as a normal wake.

// File: rtl/slow_idle_ctl.sv
module slow_idle_ctl #(
  parameter int NUM_IRQ      = 8,
  parameter int CODE_W       = 2,
  parameter int MIN_DIV_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_req,
  input  logic               div_valid,
  input  logic [CODE_W-1:0]  div_code,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               halt,
  output logic               slow_active,
  output logic               wake,
  output logic               core_ce,
  output logic               sclk_ce,
  output logic               clkout_ce,
  output logic               timer_ce
);

  localparam int MAX_LOG2 = MIN_DIV_LOG2 + (1 << CODE_W) - 1;
  localparam int CNT_W    = MAX_LOG2;

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_SLOW} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic [CODE_W-1:0] code_q;
  logic              wake_now;
  logic              tick;
  logic              periph;

  assign wake_now = |(irq_pend & irq_en);
  assign lim      = CNT_W'((32'd1 << (MIN_DIV_LOG2 + 32'(code_q))) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cnt    <= '0;
      code_q <= '0;
      wake   <= 1'b0;
    end else begin
      wake <= 1'b0;
      case (st)
        ST_RUN: begin
          if (idle_req) begin
            if (wake_now) begin
              wake <= 1'b1;
            end else if (div_valid) begin
              st     <= ST_SLOW;
              cnt    <= '0;
              code_q <= div_code;
            end else begin
              st <= ST_HALT;
            end
          end
        end
        ST_HALT: begin
          if (wake_now) begin
            st   <= ST_RUN;
            wake <= 1'b1;
          end
        end
        ST_SLOW: begin
          if (wake_now) begin
            st   <= ST_RUN;
            wake <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign halt        = (st == ST_HALT);
  assign slow_active = (st == ST_SLOW);
  assign tick        = (st == ST_RUN) || (slow_active && cnt == lim);
  assign periph      = halt || tick;
  assign core_ce     = tick;
  assign sclk_ce     = periph;
  assign clkout_ce   = periph;
  assign timer_ce    = periph;

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !slow_active && idle_req && !div_valid && !wake_now)
      |=> (halt && !core_ce && timer_ce && sclk_ce && clkout_ce));

  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wake_now) |=> halt);

  p_halt_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && wake_now) |=> (!halt && core_ce && wake));

  p_no_double_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && core_ce) |=> (!core_ce || !slow_active));

  p_slow_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_active |-> !halt);

  p_slow_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && wake_now) |=> (!slow_active && core_ce && wake));

  p_slow_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && !wake_now) |=> (slow_active && $stable(code_q)));

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !slow_active && idle_req && wake_now)
      |=> (!halt && !slow_active && wake));

  p_wake_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

endmodule

// File: tb/tb_slow_idle_ctl.sv
`timescale 1ns/1ps
module tb_slow_idle_ctl;
  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          idle_req, div_valid;
  logic [1:0]    div_code;
  logic [NI-1:0] irq_pend, irq_en;
  logic halt, slow_active, wake, core_ce, sclk_ce, clkout_ce, timer_ce;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slow_idle_ctl #(.NUM_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .div_valid(div_valid),
    .div_code(div_code), .irq_pend(irq_pend), .irq_en(irq_en),
    .halt(halt), .slow_active(slow_active), .wake(wake), .core_ce(core_ce),
    .sclk_ce(sclk_ce), .clkout_ce(clkout_ce), .timer_ce(timer_ce));

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle_req = 0; div_valid = 0; div_code = 0; irq_pend = 0; irq_en = 0;
    step(); step();
    chk("R1", "halt in reset", int'(halt), 0);
    chk("R1", "core_ce in reset", int'(core_ce), 1);
    rst_n = 1;
    step();
    chk("R1", "halt", int'(halt), 0);
    chk("R1", "slow_active", int'(slow_active), 0);
    chk("R1", "wake", int'(wake), 0);
    chk("R1", "enables", int'({core_ce, sclk_ce, clkout_ce, timer_ce}), 15);
  endtask

  task automatic t_std_idle(input logic [1:0] code);
    int held = 0;
    idle_req = 1; div_valid = 0; div_code = code;
    irq_pend = 8'h04; irq_en = 8'hFB;
    step();
    idle_req = 0;
    chk("R2", "halt after plain idle", int'(halt), 1);
    chk("R2", "core_ce while halted", int'(core_ce), 0);
    chk("R2", "derived enables while halted", int'({sclk_ce, clkout_ce, timer_ce}), 7);
    for (int k = 0; k < 20; k++) begin
      step();
      if (halt) held++;
    end
    chk("R3", "cycles halted with masked irq", held, 20);
    irq_en = 8'hFF;
    step();
    irq_pend = 0; irq_en = 0;
    chk("R4", "halt after unmasked irq", int'(halt), 0);
    chk("R4", "core_ce after wake", int'(core_ce), 1);
    chk("R4", "wake strobe", int'(wake), 1);
    step();
    chk("R11", "wake drops", int'(wake), 0);
  endtask

  task automatic t_slow(input logic [1:0] code, input bit poke);
    int n = 16 << code;
    int first = -1;
    int pulses = 0;
    int bad = 0;
    int halted = 0;
    int left = 0;
    string rq = poke ? "R9" : "R5";
    idle_req = 1; div_valid = 1; div_code = code;
    step();
    idle_req = 0; div_valid = 0;
    for (int k = 0; k < 3 * n; k++) begin
      if (k > 0) step();
      if (core_ce) begin
        pulses++;
        if (first < 0) first = k;
      end
      if (sclk_ce !== core_ce || clkout_ce !== core_ce || timer_ce !== core_ce) bad++;
      if (halt) halted++;
      if (!slow_active) left++;
      if (poke && k == 5) begin div_code = ~code; idle_req = 1; div_valid = 1; end
      if (poke && k == 6) begin idle_req = 0; div_valid = 0; end
    end
    chk(rq, "first core_ce pulse index", first, n - 1);
    chk(rq, "core_ce pulses in 3N cycles", pulses, 3);
    chk("R7", "derived enable mismatches", bad, 0);
    chk("R6", "halt cycles in slow mode", halted, 0);
    chk("R6", "cycles out of slow mode", left, 0);
    irq_pend = 8'h80; irq_en = 8'h80;
    step();
    irq_pend = 0; irq_en = 0;
    chk("R8", "slow_active after irq", int'(slow_active), 0);
    chk("R8", "core_ce after irq", int'(core_ce), 1);
    chk("R8", "wake after irq", int'(wake), 1);
    step();
    chk("R11", "wake drops after slow exit", int'(wake), 0);
    chk("R8", "core_ce stays full rate", int'(core_ce), 1);
  endtask

  task automatic t_collide(input bit with_div);
    idle_req = 1; div_valid = with_div; div_code = 2'b11;
    irq_pend = 8'h01; irq_en = 8'h01;
    step();
    idle_req = 0; div_valid = 0; irq_pend = 0; irq_en = 0;
    chk("R10", "halt on collision", int'(halt), 0);
    chk("R10", "slow_active on collision", int'(slow_active), 0);
    chk("R10", "wake on collision", int'(wake), 1);
    chk("R10", "core_ce on collision", int'(core_ce), 1);
    step();
    chk("R11", "wake drops after collision", int'(wake), 0);
    chk("R10", "still running", int'(core_ce && !halt && !slow_active), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_std_idle(2'b00);
    t_std_idle(2'b10);
    t_slow(2'b00, 0);
    t_slow(2'b01, 0);
    t_slow(2'b10, 0);
    t_slow(2'b11, 0);
    t_slow(2'b01, 1);
    t_collide(0);
    t_collide(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule